// File: doc/BRIEF.md
# Programmable Interrupt Remapper and Priority Selector

This block gathers 48 level-sensitive peripheral interrupt lines and steers each one, through its own programmable routing field, onto one of 32 central channels. Any number of sources may be routed to the same channel, so that channel is pending while any of its sources is high. Each channel can be disabled by its own mask bit and is assigned to one of two request classes, fast or normal.

Each class has its own fixed-priority selector. The lowest-numbered eligible channel wins. The selector presents a registered request flag and a 5-bit channel number, which the CPU uses as a vector index. Software reaches the routing fields, the mask word and the class word through a simple write port with a combinational read-back.

Register addresses: 0 to 47 hold the routing field of the source with the same number. 48 holds the mask word. 49 holds the class word. Any other address reads as zero.

Top module: `irq_expander`

## Requirements
- R1: After reset, the routing field of each source 0 to 30 holds its own number, and the routing fields of sources 31 to 47 hold 31. A reset asserted later restores these values.
- R2: A write to address 0 to 47 stores bits [4:0] of the write data in that source's routing field and discards the upper bits. Reading that address returns the stored field in bits [4:0], with zeros above.
- R3: A channel is pending while at least one source routed to it is high. Several sources may share one channel.
- R4: Bit c of the mask word (address 48), when set to 1, stops channel c from ever winning. The word reads back as written.
- R5: Within a class, the winning channel is the lowest-numbered eligible channel. Channel 0 has the highest priority and channel 31 the lowest.
- R6: Bit c of the class word (address 49) set to 1 puts channel c in the fast class, which drives `fast_req`/`fast_idx`. Set to 0, it puts channel c in the normal class, which drives `norm_req`/`norm_idx`. Each class selects only among its own channels.
- R7: The request flags and indices are registered. They reflect source and register state one clock edge after it changes, and they do not change before that edge.
- R8: When a class has no eligible channel, its request flag is 0 and its index is 31 (all ones).
- R9: Reset clears the mask and class words to zero, so every channel is enabled and in the normal class. Both request flags go low and both indices go to all ones, asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 48 | Level-sensitive source interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fast_req | output | 1 | Fast-class request pending |
| fast_idx | output | 5 | Winning fast-class channel |
| norm_req | output | 1 | Normal-class request pending |
| norm_idx | output | 5 | Winning normal-class channel |

## Verification
Read data follows the address in the same cycle, so the bench checks it shortly after driving the address, with no clock edge in between. A change of the source lines reaches the request outputs at the next rising edge. A register write takes effect at its own edge and reaches the outputs one edge later. The bench therefore drives on the falling edge and samples the outputs at the falling edge that follows the edge where each result is due. One check samples just before that edge to confirm the outputs have not yet moved.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
    localparam int NSRC_DEF  = 48;
    localparam int NCH_DEF   = 32;
    localparam int AW_DEF    = 6;
    localparam int DW_DEF    = 32;
    localparam int NCLASS    = 2;
    localparam int CLS_NORM  = 0;
    localparam int CLS_FAST  = 1;
endpackage

// File: rtl/irqx_regs.sv
module irqx_regs
    import irqx_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int NCH  = NCH_DEF,
    parameter int AW   = AW_DEF,
    parameter int DW   = DW_DEF,
    localparam int CW  = $clog2(NCH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       wdata,
    output logic [DW-1:0]       rdata,
    output logic [NSRC*CW-1:0]  route_flat,
    output logic [NCH-1:0]      mask_q,
    output logic [NCH-1:0]      class_q
);
    localparam int ADDR_MASK  = NSRC;
    localparam int ADDR_CLASS = NSRC + 1;

    logic [CW-1:0] route_q [NSRC];

    for (genvar s = 0; s < NSRC; s++) begin : g_route
        localparam logic [CW-1:0] RST_CH = (s < NCH - 1) ? CW'(s) : CW'(NCH - 1);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                route_q[s] <= RST_CH;
            else if (we && (32'(addr) == s))
                route_q[s] <= wdata[CW-1:0];
        end
        assign route_flat[s*CW +: CW] = route_q[s];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '0;
            class_q <= '0;
        end else if (we) begin
            if (32'(addr) == ADDR_MASK)  mask_q  <= wdata[NCH-1:0];
            if (32'(addr) == ADDR_CLASS) class_q <= wdata[NCH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (32'(addr) < NSRC)
            rdata[CW-1:0] = route_q[addr];
        else if (32'(addr) == ADDR_MASK)
            rdata[NCH-1:0] = mask_q;
        else if (32'(addr) == ADDR_CLASS)
            rdata[NCH-1:0] = class_q;
    end
endmodule

// File: rtl/irqx_route.sv
module irqx_route
    import irqx_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int NCH  = NCH_DEF,
    localparam int CW  = $clog2(NCH)
) (
    input  logic [NSRC-1:0]     src,
    input  logic [NSRC*CW-1:0]  route_flat,
    output logic [NCH-1:0]      pend
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [NSRC-1:0] hit;
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign hit[s] = src[s] && (route_flat[s*CW +: CW] == CW'(c));
        end
        assign pend[c] = |hit;
    end
endmodule

// File: rtl/irqx_prio.sv
module irqx_prio
    import irqx_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    localparam int CW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  elig,
    output logic            req_q,
    output logic [CW-1:0]   idx_q
);
    logic [CW-1:0] win;

    always_comb begin
        win = '1;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (elig[i]) win = CW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            idx_q <= '1;
        end else begin
            req_q <= |elig;
            idx_q <= win;
        end
    end
endmodule

// File: rtl/irq_expander.sv
module irq_expander
    import irqx_pkg::*;
#(
    parameter int NSRC = NSRC_DEF,
    parameter int NCH  = NCH_DEF,
    parameter int AW   = AW_DEF,
    parameter int DW   = DW_DEF,
    localparam int CW  = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic            reg_we,
    input  logic [AW-1:0]   reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            fast_req,
    output logic [CW-1:0]   fast_idx,
    output logic            norm_req,
    output logic [CW-1:0]   norm_idx
);
    logic [NSRC*CW-1:0] route_flat;
    logic [NCH-1:0]     mask_q;
    logic [NCH-1:0]     class_q;
    logic [NCH-1:0]     chan_pend;
    logic [NCLASS-1:0]  cls_req;
    logic [CW-1:0]      cls_idx [NCLASS];

    irqx_regs #(.NSRC(NSRC), .NCH(NCH), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .route_flat(route_flat),
        .mask_q(mask_q), .class_q(class_q)
    );

    irqx_route #(.NSRC(NSRC), .NCH(NCH)) u_route (
        .src(src_req), .route_flat(route_flat), .pend(chan_pend)
    );

    for (genvar t = 0; t < NCLASS; t++) begin : g_cls
        logic [NCH-1:0] elig;
        assign elig = chan_pend & ~mask_q & ((t == CLS_FAST) ? class_q : ~class_q);
        irqx_prio #(.NCH(NCH)) u_prio (
            .clk(clk), .rst_n(rst_n), .elig(elig),
            .req_q(cls_req[t]), .idx_q(cls_idx[t])
        );
    end

    assign fast_req = cls_req[CLS_FAST];
    assign fast_idx = cls_idx[CLS_FAST];
    assign norm_req = cls_req[CLS_NORM];
    assign norm_idx = cls_idx[CLS_NORM];
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
    parameter int NCH = 32,
    localparam int CW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] chan_pend,
    input logic [NCH-1:0] mask_q,
    input logic [NCH-1:0] class_q,
    input logic           fast_req,
    input logic [CW-1:0]  fast_idx,
    input logic           norm_req,
    input logic [CW-1:0]  norm_idx
);
    logic [NCH-1:0] el_n, el_f, prev_n, prev_f, prev_mask;
    logic           started;

    assign el_n = chan_pend & ~mask_q & ~class_q;
    assign el_f = chan_pend & ~mask_q & class_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started   <= 1'b0;
            prev_n    <= '0;
            prev_f    <= '0;
            prev_mask <= '0;
        end else begin
            started   <= 1'b1;
            prev_n    <= el_n;
            prev_f    <= el_f;
            prev_mask <= mask_q;
        end
    end

    AST_NORM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (norm_req == (|prev_n))); // R7
    AST_FAST_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (fast_req == (|prev_f))); // R6
    AST_NORM_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !norm_req |-> (norm_idx == '1)); // R8
    AST_FAST_IDLE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_req |-> (fast_idx == '1)); // R8
    AST_NORM_TOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (started && norm_req) |-> (prev_n[norm_idx] &&
            ((prev_n & ((NCH'(1) << norm_idx) - NCH'(1))) == '0))); // R5
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (started && norm_req) |-> !prev_mask[norm_idx]); // R4
endmodule

bind irq_expander irqx_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .chan_pend(chan_pend), .mask_q(mask_q),
    .class_q(class_q), .fast_req(fast_req), .fast_idx(fast_idx),
    .norm_req(norm_req), .norm_idx(norm_idx)
);

// File: tb/sim_irq_expander.sv
module sim_irq_expander;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] src_req = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fast_req, norm_req;
    logic [4:0]  fast_idx, norm_idx;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_expander u0 (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fast_req(fast_req), .fast_idx(fast_idx),
        .norm_req(norm_req), .norm_idx(norm_idx)
    );

    // default routing, all normal: expected {req, idx} of the normal class
    localparam logic [47:0] VSRC [NV] = '{
        48'h0,
        48'h0000_0000_0020,
        48'h0000_0000_0028,
        48'h0100_0000_0000,
        48'h8000_0000_0001,
        48'h0000_4000_0000,
        48'h0000_8000_0000,
        48'h0000_0010_1000
    };
    localparam logic [5:0] VEXP [NV] = '{
        6'h1F, 6'h25, 6'h23, 6'h3F, 6'h20, 6'h3E, 6'h3F, 6'h2C
    };

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string rq, input logic [5:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(rq, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 norm", {26'b0, norm_req, norm_idx}, 32'h1F);
        check("R9 fast", {26'b0, fast_req, fast_idx}, 32'h1F);
        rst_n = 1'b1;
        tick();
        rd_check("R9 mask", 6'd48, 32'h0);
        rd_check("R9 class", 6'd49, 32'h0);
        rd_check("R1 map0", 6'd0, 32'd0);
        rd_check("R1 map30", 6'd30, 32'd30);
        rd_check("R1 map47", 6'd47, 32'd31);

        // R5 R3 table of default-routing vectors
        for (int i = 0; i < NV; i++) begin
            src_req = VSRC[i];
            tick();
            check($sformatf("R5 vec%0d", i), {26'b0, norm_req, norm_idx}, {26'b0, VEXP[i]});
            check("R6 fast idle", {26'b0, fast_req, fast_idx}, 32'h1F);
        end
        src_req = '0;
        tick();

        // R2: upper write bits discarded
        wr(6'd40, 32'hFFFF_FFE2);
        rd_check("R2 map40", 6'd40, 32'h2);
        // R3: source 40 now shares channel 2
        src_req = 48'h0100_0000_0000;
        tick();
        check("R3 shared", {26'b0, norm_req, norm_idx}, 32'h22);
        src_req = 48'h8100_0000_0000;
        tick();
        check("R3 or", {26'b0, norm_req, norm_idx}, 32'h22);
        // R4: mask channel 2
        wr(6'd48, 32'h4);
        rd_check("R4 readback", 6'd48, 32'h4);
        tick();
        check("R4 masked", {26'b0, norm_req, norm_idx}, 32'h3F);
        // R7: no change before the edge
        src_req = 48'h0100_0000_0080;
        #1;
        check("R7 hold", {26'b0, norm_req, norm_idx}, 32'h3F);
        tick();
        check("R7 due", {26'b0, norm_req, norm_idx}, 32'h27);
        // R6: channel 7 to fast class
        wr(6'd49, 32'h80);
        tick();
        check("R6 fast", {26'b0, fast_req, fast_idx}, 32'h27);
        check("R8 norm idle", {26'b0, norm_req, norm_idx}, 32'h1F);
        src_req = '0;
        tick();
        check("R8 fast idle", {26'b0, fast_req, fast_idx}, 32'h1F);
        // R1: later reset restores defaults
        src_req = 48'h0000_0000_0080;
        tick();
        rst_n = 1'b0;
        #1;
        check("R9 async", {26'b0, fast_req, fast_idx}, 32'h1F);
        rd_check("R1 map40 restored", 6'd40, 32'd31);
        rd_check("R9 class cleared", 6'd49, 32'h0);
        rst_n = 1'b1;
        tick();
        check("R6 back to norm", {26'b0, norm_req, norm_idx}, 32'h27);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule